// File: doc/BRIEF.md
# Operand Forwarding and Interlock Unit

This block holds the data-dependence control of a five-stage in-order pipeline with eight architectural registers. Each cycle it looks at the instruction sitting in decode and at the `DEPTH` older instructions still in flight. It then decides where each of the two execute operands should come from: the register file read, or the result of one specific older instruction. It also decides whether decode must wait.

Older instructions are presented by distance. Slot 0 holds the instruction one step older than decode, which is the one now entering execute. Slot 3 holds the one that has just left writeback. The unit drives the hold controls for the program counter and the fetch/decode register, and requests a bubble into execute. The chosen operand sources are captured at the clock edge, so that the execute stage applies them one cycle later.

A mode input switches the unit between two policies. In the forwarding policy, an interlock occurs only when a load result is not ready yet. In the pure interlock policy, nothing is forwarded and decode waits until no dependence remains.

Top module: `hzfw_unit`

## Requirements
- R1: Class codes are 3 bits: 0 empty/noop, 1 add, 2 nand, 3 load, 4 store, 5 branch-equal. Register specifiers are 3 bits, and register 0 has no special meaning.
- R2: Each registered select means the following: 0 selects the register file, and k (1..DEPTH) selects the result of the producer k slots older than decode. When several producers match, the youngest one (smallest k) wins.
- R3: Only add, nand and load count as producers. Store, branch and empty slots never match. A source that the decode class does not read never matches: load reads only A, noop reads neither, and every other class reads A and B.
- R4: Register 0 is forwarded and interlocked exactly like any other register.
- R5: A match against the producer that has just left writeback (distance DEPTH) is forwarded with select DEPTH.
- R6: In forwarding mode, a load at distance 1 whose destination is read by decode raises the stall for one cycle. On the next cycle the load is at distance 2, and it is forwarded with select 2.
- R7: Whenever the stall is raised, pc_en and ifid_en are 0 and ex_bubble is 1 in the same cycle. Otherwise pc_en and ifid_en are 1 and ex_bubble is 0.
- R8: The selects are registered at the rising clock edge. After a cycle in which the stall was raised, both registered selects are 0.
- R9: When fwd_en is 0, interlock_mode is 1 and both registered selects are 0. The stall is raised whenever any matching producer exists at any distance 1..DEPTH.
- R10: While rst_n is low, both registered selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | 1 selects the forwarding policy, 0 selects the pure interlock policy |
| dec_cls | input | 3 | Class of the instruction in decode |
| dec_src_a | input | REG_W | First source register of the decode instruction |
| dec_src_b | input | REG_W | Second source register of the decode instruction |
| prod_cls | input | DEPTH x 3 | Class of each older slot; index 0 is distance 1 |
| prod_dst | input | DEPTH x REG_W | Destination register of each older slot |
| stall | output | 1 | Decode must wait this cycle |
| pc_en | output | 1 | Program counter may advance |
| ifid_en | output | 1 | Fetch/decode register may load |
| ex_bubble | output | 1 | Insert a noop into execute |
| interlock_mode | output | 1 | Unit is in the pure interlock policy |
| fwd_sel_a | output | SEL_W | Registered source select for operand A |
| fwd_sel_b | output | SEL_W | Registered source select for operand B |

## Verification
The hardest situation to reach from the ports is a consistent pipeline history: a load that stalls must reappear one slot further on with a noop behind it. Distance-4 matches must also coexist with younger shadowing producers. The bench therefore keeps its own queue of in-flight instructions and a program queue. Each cycle it shifts the history, inserting a noop on a predicted stall. This lets directed sequences and a long random stream with mode flips reproduce real back-to-back dependence patterns.

// File: rtl/hzfw_pkg.sv
package hzfw_pkg;

   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      OP_NOP  = 3'd0,
      OP_ADD  = 3'd1,
      OP_NAND = 3'd2,
      OP_LW   = 3'd3,
      OP_SW   = 3'd4,
      OP_BEQ  = 3'd5
   } op_cls_e;

   function automatic logic writes_reg(input logic [CLS_W-1:0] c);
      return (c == OP_ADD) || (c == OP_NAND) || (c == OP_LW);
   endfunction

   function automatic logic is_load(input logic [CLS_W-1:0] c);
      return (c == OP_LW);
   endfunction

   function automatic logic reads_a(input logic [CLS_W-1:0] c);
      return (c == OP_ADD) || (c == OP_NAND) || (c == OP_LW) ||
             (c == OP_SW)  || (c == OP_BEQ);
   endfunction

   function automatic logic reads_b(input logic [CLS_W-1:0] c);
      return (c == OP_ADD) || (c == OP_NAND) ||
             (c == OP_SW)  || (c == OP_BEQ);
   endfunction

endpackage

// File: rtl/hzfw_cmp.sv
// Compares one source specifier against every older producer slot.
module hzfw_cmp #(
   parameter int REG_W = 3,
   parameter int DEPTH = 4
) (
   input  logic [REG_W-1:0]            src,
   input  logic                        src_used,
   input  logic [DEPTH-1:0]            prod_wr,
   input  logic [DEPTH-1:0][REG_W-1:0] prod_dst,
   output logic [DEPTH-1:0]            hit
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign hit[i] = src_used && prod_wr[i] && (prod_dst[i] == src);
   end

endmodule

// File: rtl/hzfw_prio.sv
// Picks the youngest matching slot; slot i encodes as i+1, none as 0.
module hzfw_prio #(
   parameter int DEPTH = 4,
   parameter int SEL_W = 3
) (
   input  logic [DEPTH-1:0] hit,
   output logic [SEL_W-1:0] sel
);

   always_comb begin
      sel = '0;
      for (int d = DEPTH - 1; d >= 0; d--) begin
         if (hit[d]) sel = SEL_W'(d + 1);
      end
   end

endmodule

// File: rtl/hzfw_ctl.sv
// Decides whether decode waits, under either policy.
module hzfw_ctl #(
   parameter int DEPTH    = 4,
   parameter int LOAD_GAP = 1
) (
   input  logic             fwd_en,
   input  logic [DEPTH-1:0] hit_a,
   input  logic [DEPTH-1:0] hit_b,
   input  logic [DEPTH-1:0] prod_ld,
   output logic             stall
);

   logic [DEPTH-1:0] late_mask;
   logic [DEPTH-1:0] hit_any;
   logic             wait_load;
   logic             wait_any;

   // Slots closer than LOAD_GAP cannot yet supply a loaded value.
   for (genvar i = 0; i < DEPTH; i++) begin : g_mask
      if (i < LOAD_GAP) begin : g_late
         assign late_mask[i] = 1'b1;
      end else begin : g_ready
         assign late_mask[i] = 1'b0;
      end
   end

   assign hit_any   = hit_a | hit_b;
   assign wait_load = |(hit_any & prod_ld & late_mask);
   assign wait_any  = |hit_any;
   assign stall     = fwd_en ? wait_load : wait_any;

endmodule

// File: rtl/hzfw_unit.sv
module hzfw_unit #(
   parameter int REG_W    = 3,
   parameter int DEPTH    = 4,
   parameter int LOAD_GAP = 1,
   localparam int CLS_W   = hzfw_pkg::CLS_W,
   localparam int SEL_W   = $clog2(DEPTH + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fwd_en,
   input  logic [CLS_W-1:0]            dec_cls,
   input  logic [REG_W-1:0]            dec_src_a,
   input  logic [REG_W-1:0]            dec_src_b,
   input  logic [DEPTH-1:0][CLS_W-1:0] prod_cls,
   input  logic [DEPTH-1:0][REG_W-1:0] prod_dst,
   output logic                        stall,
   output logic                        pc_en,
   output logic                        ifid_en,
   output logic                        ex_bubble,
   output logic                        interlock_mode,
   output logic [SEL_W-1:0]            fwd_sel_a,
   output logic [SEL_W-1:0]            fwd_sel_b
);

   if (REG_W < 1) begin : g_bad_regw
      $error("hzfw_unit: REG_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("hzfw_unit: DEPTH must be at least 2");
   end
   if (LOAD_GAP < 0 || LOAD_GAP >= DEPTH) begin : g_bad_gap
      $error("hzfw_unit: LOAD_GAP must lie in 0..DEPTH-1");
   end

   logic [DEPTH-1:0] prod_wr;
   logic [DEPTH-1:0] prod_ld;

   for (genvar i = 0; i < DEPTH; i++) begin : g_decode
      assign prod_wr[i] = hzfw_pkg::writes_reg(prod_cls[i]);
      assign prod_ld[i] = hzfw_pkg::is_load(prod_cls[i]);
   end

   logic             use_a, use_b;
   logic [DEPTH-1:0] hit_a, hit_b;
   logic [SEL_W-1:0] pick_a, pick_b;
   logic             stall_w;

   assign use_a = hzfw_pkg::reads_a(dec_cls);
   assign use_b = hzfw_pkg::reads_b(dec_cls);

   hzfw_cmp #(.REG_W(REG_W), .DEPTH(DEPTH)) u_cmp_a (
      .src(dec_src_a), .src_used(use_a), .prod_wr(prod_wr),
      .prod_dst(prod_dst), .hit(hit_a));

   hzfw_cmp #(.REG_W(REG_W), .DEPTH(DEPTH)) u_cmp_b (
      .src(dec_src_b), .src_used(use_b), .prod_wr(prod_wr),
      .prod_dst(prod_dst), .hit(hit_b));

   hzfw_prio #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_prio_a (
      .hit(hit_a), .sel(pick_a));

   hzfw_prio #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_prio_b (
      .hit(hit_b), .sel(pick_b));

   hzfw_ctl #(.DEPTH(DEPTH), .LOAD_GAP(LOAD_GAP)) u_ctl (
      .fwd_en(fwd_en), .hit_a(hit_a), .hit_b(hit_b),
      .prod_ld(prod_ld), .stall(stall_w));

   assign stall          = stall_w;
   assign pc_en          = !stall_w;
   assign ifid_en        = !stall_w;
   assign ex_bubble      = stall_w;
   assign interlock_mode = !fwd_en;

   logic             take;
   logic [SEL_W-1:0] sel_a_q, sel_b_q;

   assign take = fwd_en && !stall_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_a_q <= '0;
         sel_b_q <= '0;
      end else begin
         sel_a_q <= take ? pick_a : '0;
         sel_b_q <= take ? pick_b : '0;
      end
   end

   assign fwd_sel_a = sel_a_q;
   assign fwd_sel_b = sel_b_q;

endmodule

// File: rtl/hzfw_unit_chk.sv
module hzfw_unit_chk #(
   parameter int REG_W    = 3,
   parameter int DEPTH    = 4,
   parameter int LOAD_GAP = 1,
   localparam int CLS_W   = hzfw_pkg::CLS_W,
   localparam int SEL_W   = $clog2(DEPTH + 1)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        fwd_en,
   input logic [CLS_W-1:0]            dec_cls,
   input logic [REG_W-1:0]            dec_src_a,
   input logic [REG_W-1:0]            dec_src_b,
   input logic [DEPTH-1:0][CLS_W-1:0] prod_cls,
   input logic [DEPTH-1:0][REG_W-1:0] prod_dst,
   input logic                        stall,
   input logic                        pc_en,
   input logic                        ifid_en,
   input logic                        ex_bubble,
   input logic                        interlock_mode,
   input logic [SEL_W-1:0]            fwd_sel_a,
   input logic [SEL_W-1:0]            fwd_sel_b
);

   logic any_writer;
   logic near_load_hit;

   always_comb begin
      any_writer = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (prod_cls[i] == hzfw_pkg::OP_ADD || prod_cls[i] == hzfw_pkg::OP_NAND ||
             prod_cls[i] == hzfw_pkg::OP_LW)
            any_writer = 1'b1;
      end
   end

   assign near_load_hit = (prod_cls[0] == hzfw_pkg::OP_LW) &&
      (((dec_cls != hzfw_pkg::OP_NOP) && (prod_dst[0] == dec_src_a)) ||
       ((dec_cls != hzfw_pkg::OP_NOP) && (dec_cls != hzfw_pkg::OP_LW) &&
        (prod_dst[0] == dec_src_b)));

   p_load_use_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_en && near_load_hit) |-> stall);

   p_bubble_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (fwd_sel_a == '0 && fwd_sel_b == '0));

   p_no_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_en |=> (fwd_sel_a == '0 && fwd_sel_b == '0 && $past(interlock_mode)));

   p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !any_writer |-> (!stall && pc_en && ifid_en && !ex_bubble));

   p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(fwd_sel_a) <= DEPTH && int'(fwd_sel_b) <= DEPTH));

endmodule

bind hzfw_unit hzfw_unit_chk #(.REG_W(REG_W), .DEPTH(DEPTH), .LOAD_GAP(LOAD_GAP)) u_chk (
   .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .dec_cls(dec_cls),
   .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .prod_cls(prod_cls),
   .prod_dst(prod_dst), .stall(stall), .pc_en(pc_en), .ifid_en(ifid_en),
   .ex_bubble(ex_bubble), .interlock_mode(interlock_mode),
   .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b));

// File: tb/hzfw_unit_test.sv
module hzfw_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int NSLOT = 4;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  fwd_en = 1'b1;
   logic [2:0]            dec_cls = '0;
   logic [2:0]            dec_src_a = '0;
   logic [2:0]            dec_src_b = '0;
   logic [NSLOT-1:0][2:0] prod_cls = '0;
   logic [NSLOT-1:0][2:0] prod_dst = '0;
   logic                  stall, pc_en, ifid_en, ex_bubble, interlock_mode;
   logic [2:0]            fwd_sel_a, fwd_sel_b;

   hzfw_unit uut (
      .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .dec_cls(dec_cls),
      .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .prod_cls(prod_cls),
      .prod_dst(prod_dst), .stall(stall), .pc_en(pc_en), .ifid_en(ifid_en),
      .ex_bubble(ex_bubble), .interlock_mode(interlock_mode),
      .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // In-flight history (index 0 = distance 1) and pending program.
   int h_cls[NSLOT];
   int h_dst[NSLOT];
   int p_cls[$], p_a[$], p_b[$], p_d[$];
   string tag = "R1";

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit wr(int c);
      return c == 1 || c == 2 || c == 3;
   endfunction

   function automatic bit uses_a(int c);
      return c >= 1 && c <= 5;
   endfunction

   function automatic bit uses_b(int c);
      return c == 1 || c == 2 || c == 4 || c == 5;
   endfunction

   function automatic int ref_sel(int src, bit used);
      if (!used) return 0;
      for (int d = 0; d < NSLOT; d++)
         if (wr(h_cls[d]) && h_dst[d] == src) return d + 1;
      return 0;
   endfunction

   function automatic bit ref_stall(int c, int a, int b, bit fe);
      if (fe)
         return h_cls[0] == 3 &&
                ((uses_a(c) && h_dst[0] == a) || (uses_b(c) && h_dst[0] == b));
      return ref_sel(a, uses_a(c)) != 0 || ref_sel(b, uses_b(c)) != 0;
   endfunction

   task automatic add_insn(int c, int a, int b, int d);
      p_cls.push_back(c); p_a.push_back(a); p_b.push_back(b); p_d.push_back(d);
   endtask

   task automatic clear_hist();
      for (int i = 0; i < NSLOT; i++) begin h_cls[i] = 0; h_dst[i] = 0; end
   endtask

   // One cycle: called just after a falling edge.
   task automatic one_cycle();
      int c, a, b, d;
      bit es;
      int ea, eb;
      string stag;
      if (p_cls.size() > 0) begin
         c = p_cls[0]; a = p_a[0]; b = p_b[0]; d = p_d[0];
      end else begin
         c = 0; a = 0; b = 0; d = 0;
      end
      dec_cls = 3'(c); dec_src_a = 3'(a); dec_src_b = 3'(b);
      for (int i = 0; i < NSLOT; i++) begin
         prod_cls[i] = 3'(h_cls[i]);
         prod_dst[i] = 3'(h_dst[i]);
      end
      #(CLK_PERIOD/4);
      es = ref_stall(c, a, b, fwd_en);
      ea = (fwd_en && !es) ? ref_sel(a, uses_a(c)) : 0;
      eb = (fwd_en && !es) ? ref_sel(b, uses_b(c)) : 0;
      stag = (tag == "R6" || tag == "R9") ? tag : "R7";
      check(stag, int'(stall), int'(es));
      check("R7", int'(pc_en), int'(!es));
      check("R7", int'(ifid_en), int'(!es));
      check("R7", int'(ex_bubble), int'(es));
      check("R9", int'(interlock_mode), int'(!fwd_en));
      @(posedge clk);
      #1;
      stag = es ? "R8" : (!fwd_en ? "R9" : tag);
      check(stag, int'(fwd_sel_a), ea);
      check(stag, int'(fwd_sel_b), eb);
      for (int i = NSLOT - 1; i > 0; i--) begin
         h_cls[i] = h_cls[i-1]; h_dst[i] = h_dst[i-1];
      end
      if (es) begin
         h_cls[0] = 0; h_dst[0] = 0;
      end else begin
         h_cls[0] = c; h_dst[0] = d;
         if (p_cls.size() > 0) begin
            void'(p_cls.pop_front()); void'(p_a.pop_front());
            void'(p_b.pop_front()); void'(p_d.pop_front());
         end
      end
      @(negedge clk);
   endtask

   task automatic run_prog(int extra);
      int guard = 0;
      while (p_cls.size() > 0 && guard < 1000) begin
         one_cycle();
         guard++;
      end
      for (int i = 0; i < extra; i++) one_cycle();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      clear_hist();
      // R10: selects held at zero during reset, even with a forwardable pattern.
      dec_cls = 3'd1; dec_src_a = 3'd5; dec_src_b = 3'd5;
      prod_cls[0] = 3'd1; prod_dst[0] = 3'd5;
      repeat (3) @(posedge clk);
      #1;
      check("R10", int'(fwd_sel_a), 0);
      check("R10", int'(fwd_sel_b), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: register 0 forwarded from distance 1.
      tag = "R4";
      add_insn(1, 1, 2, 0);
      add_insn(2, 0, 0, 4);
      run_prog(4);

      // R2: youngest producer wins; distances 2 and 3 also exercised.
      tag = "R2";
      add_insn(1, 1, 2, 3);
      add_insn(2, 4, 5, 3);
      add_insn(1, 3, 6, 7);
      add_insn(0, 0, 0, 0);
      add_insn(1, 7, 3, 1);
      add_insn(2, 7, 3, 2);
      run_prog(4);

      // R5: producer just left writeback.
      tag = "R5";
      add_insn(1, 1, 2, 6);
      add_insn(0, 0, 0, 0);
      add_insn(0, 0, 0, 0);
      add_insn(0, 0, 0, 0);
      add_insn(2, 6, 1, 5);
      run_prog(4);

      // R3: store/branch never match; load ignores its B field; noop reads nothing.
      tag = "R3";
      add_insn(4, 1, 2, 2);
      add_insn(5, 1, 2, 3);
      add_insn(1, 2, 3, 4);
      add_insn(1, 1, 1, 5);
      add_insn(3, 0, 5, 6);
      add_insn(0, 6, 6, 0);
      run_prog(4);

      // R6: load followed by its user: one stall, then select 2.
      tag = "R6";
      add_insn(3, 1, 0, 2);
      add_insn(1, 2, 4, 5);
      add_insn(3, 5, 0, 6);
      add_insn(4, 7, 6, 0);
      run_prog(4);

      // R9: pure interlock mode waits out the whole window.
      tag = "R9";
      fwd_en = 1'b0;
      add_insn(1, 1, 2, 3);
      add_insn(2, 3, 4, 5);
      add_insn(1, 5, 3, 7);
      run_prog(3);
      fwd_en = 1'b1;
      run_prog(2);

      // R1: random class/field mix with occasional mode flips.
      tag = "R1";
      for (int n = 0; n < 600; n++) begin
         if (p_cls.size() == 0)
            add_insn($urandom_range(0, 5), $urandom_range(0, 7),
                     $urandom_range(0, 7), $urandom_range(0, 7));
         if (n % 97 == 50) fwd_en = ~fwd_en;
         one_cycle();
      end
      fwd_en = 1'b1;
      run_prog(4);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule